// File: doc/BRIEF.md
# Calendar Real-Time Clock with Masked Alarm

This block is a bus-mapped calendar clock. A reference tick input, typically a 32768 Hz enable pulse in the core clock domain, is divided down to one-second strobes. The strobes drive a cascade of calendar counters: seconds, minutes, hours, day of month, day of week, day of year, month and year. February has 29 days in years divisible by four. A signed periodic calibration can add or drop one second every N seconds.

After each second update, the counters are compared with a bank of alarm values. A mask can exclude any field from the comparison. Per-field increment events, selected by an enable mask, and alarm matches set sticky flags that drive a single interrupt line. Software sets and reads the time through individual counter registers or through three packed read-only time words. Five scratch words are also provided.

All bus accesses are single-cycle. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every counter reads 0, the alarm mask (0x10) reads 0xFF, clock control (0x08) reads 0, the flag register (0x00) reads 0, and `irq` is low.
- R2: With control bit 0 set, one second elapses every DIV_TICKS reference ticks. While control bit 1 is set, the divider is held at zero and no second elapses.
- R3: Seconds (0x20) and minutes (0x24) wrap from 59 to 0, and each wrap increments the next field. Hours (0x28) wrap from 23 to 0. Day of week (0x30) counts 0 to 6 and wraps to 0.
- R4: Day of month (0x2C) wraps to 1 after the month's last day and increments month (0x38). Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when year (0x3C) bits [1:0] are 0, and 28 days otherwise. All other months have 31 days. Day of year (0x34) increments on every new day.
- R5: When month 12 ends, month becomes 1, year increments and day of year becomes 1.
- R6: A write to any counter register is visible on the next read, with no second elapsing.
- R7: Word 0x14 holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of week in [26:24]. Word 0x18 holds day of month in [4:0], month in [11:8] and year in [27:16]. Word 0x1C holds day of year in [11:0].
- R8: On the cycle after a second elapses, flag bit 1 is set if every unmasked field equals its alarm register (0x60 to 0x7C, in counter order). Alarm mask bits 0 to 7 exclude seconds, minutes, hours, day of month, day of week, day of year, month and year respectively.
- R9: With the alarm mask at 0xFF, no alarm flag is ever set.
- R10: Flag bit 0 is set when a field changes whose bit is set in the increment-enable register (0x0C), which uses the same bit order as the alarm mask.
- R11: Writing 1 to a flag bit clears it. `irq` is high exactly while either flag bit is set.
- R12: Calibration (0x40) holds an interval in [16:0] and a direction in [17]. When the interval is nonzero and control bit 4 is clear, every interval-th second is dropped (direction 1) or followed by one extra second on the next cycle (direction 0).
- R13: The scratch words at 0x44, 0x48, 0x4C, 0x50 and 0x54 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refTick | input | 1 | Reference tick enable counted by the divider |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irq | output | 1 | Interrupt: OR of the two sticky flags |

## Verification
A wrong carry or month-length decision stays hidden until the affected boundary is crossed. The bench therefore starts from the last second before each boundary: end of day, end of a non-leap February, end of a leap February, and end of year. It reads every field one cycle after the run stops. A wrong divider or calibration state shows as a second count that is off by one or more after a run of known length. A wrong compare or mask state shows as `irq` rising, or failing to rise, on the cycle after the matching second.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_FLAGS   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h08;
  localparam logic [ADDR_W-1:0] A_INC_EN  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_AMASK   = 8'h10;
  localparam logic [ADDR_W-1:0] A_WORD0   = 8'h14;
  localparam logic [ADDR_W-1:0] A_WORD1   = 8'h18;
  localparam logic [ADDR_W-1:0] A_WORD2   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_SEC     = 8'h20;
  localparam logic [ADDR_W-1:0] A_MIN     = 8'h24;
  localparam logic [ADDR_W-1:0] A_HOUR    = 8'h28;
  localparam logic [ADDR_W-1:0] A_DOM     = 8'h2C;
  localparam logic [ADDR_W-1:0] A_DOW     = 8'h30;
  localparam logic [ADDR_W-1:0] A_DOY     = 8'h34;
  localparam logic [ADDR_W-1:0] A_MON     = 8'h38;
  localparam logic [ADDR_W-1:0] A_YEAR    = 8'h3C;
  localparam logic [ADDR_W-1:0] A_CAL     = 8'h40;
  localparam logic [ADDR_W-1:0] A_SCRATCH = 8'h44;
  localparam logic [ADDR_W-1:0] A_ALARM   = 8'h60;  // alarm bank, same order as counters

  // strobes from control to datapath
  typedef struct packed {
    logic tick;   // one calendar second elapses this cycle
  } rtcStrobeT;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV_TICKS = 32768,
  parameter int CAL_W     = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] ctrlRdata,
  output rtcStrobeT         strobe
);
  localparam int DIV_W = (DIV_TICKS > 2) ? $clog2(DIV_TICKS) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_TICKS - 1);

  logic             runEn, divRst, calOff, calBack, extraPend;
  logic [CAL_W-1:0] calVal, calCnt;
  logic [DIV_W-1:0] divCnt;
  logic             secEdge, calActive, calEvent;
  logic             unusedWdata;

  assign unusedWdata = ^busWdata[DATA_W-1:CAL_W+1];

  assign secEdge   = runEn && !divRst && refTick && (divCnt == DIV_LAST);
  assign calActive = !calOff && (calVal != '0);
  assign calEvent  = secEdge && calActive && (calCnt == calVal - 1'b1);
  assign strobe.tick = (secEdge && !(calEvent && calBack)) || extraPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn <= 1'b0; divRst <= 1'b0; calOff <= 1'b0;
      calVal <= '0; calBack <= 1'b0;
      divCnt <= '0; calCnt <= '0; extraPend <= 1'b0;
    end else begin
      if (busWe && busAddr == A_CTRL) begin
        runEn  <= busWdata[0];
        divRst <= busWdata[1];
        calOff <= busWdata[4];
      end
      if (busWe && busAddr == A_CAL) begin
        calVal  <= busWdata[CAL_W-1:0];
        calBack <= busWdata[CAL_W];
      end
      if (divRst)
        divCnt <= '0;
      else if (runEn && refTick)
        divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
      if (divRst || !calActive)
        calCnt <= '0;
      else if (secEdge)
        calCnt <= calEvent ? '0 : calCnt + 1'b1;
      extraPend <= calEvent && !calBack;
    end
  end

  always_comb begin
    ctrlRdata = '0;
    if (busAddr == A_CTRL) ctrlRdata = {27'd0, calOff, 2'd0, divRst, runEn};
    if (busAddr == A_CAL)  ctrlRdata = DATA_W'({calBack, calVal});
  end

  // R2: a held divider produces no second of its own
  assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (divRst && !extraPend) |-> !strobe.tick);
  // R12: a forward correction adds a second on the following cycle
  assert_cal_extra_R12: assert property (@(posedge clk) disable iff (!rstN)
    (calEvent && !calBack) |=> strobe.tick);
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int YEAR_W = 12,
  parameter int GP_N   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobeT         strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] dpRdata,
  output logic              irq
);
  logic [5:0] secCnt, minCnt, alSec, alMin;
  logic [4:0] hourCnt, domCnt, alHour, alDom, monLen;
  logic [2:0] dowCnt, alDow;
  logic [8:0] doyCnt, alDoy;
  logic [3:0] monCnt, alMon;
  logic [YEAR_W-1:0] yearCnt, alYear;
  logic [7:0] amask, incEn, fieldChg, fieldEq;
  logic [1:0] flags;
  logic       alarmChk, alarmHit, incHit;
  logic       secWrap, minWrap, dayInc, monWrap, yearInc;
  logic       wrFlags, anyCntWr;
  logic [DATA_W-1:0] gp [GP_N];

  function automatic logic wrAt(input logic [ADDR_W-1:0] a);
    return busWe && busAddr == a;
  endfunction

  always_comb begin
    case (monCnt)
      4'd2:                      monLen = (yearCnt[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   monLen = 5'd30;
      default:                   monLen = 5'd31;
    endcase
  end

  assign secWrap = secCnt == 6'd59;
  assign minWrap = secWrap && minCnt == 6'd59;
  assign dayInc  = minWrap && hourCnt == 5'd23;
  assign monWrap = dayInc && domCnt >= monLen;
  assign yearInc = monWrap && monCnt >= 4'd12;
  assign fieldChg = {yearInc, monWrap, dayInc, dayInc, dayInc, minWrap, secWrap, 1'b1}
                    & {8{strobe.tick}};
  assign fieldEq = {alYear == yearCnt, alMon == monCnt, alDoy == doyCnt, alDow == dowCnt,
                    alDom == domCnt, alHour == hourCnt, alMin == minCnt, alSec == secCnt};
  assign alarmHit = alarmChk && amask != 8'hFF && (&(fieldEq | amask));
  assign incHit   = |(fieldChg & incEn);
  assign wrFlags  = wrAt(A_FLAGS);
  assign anyCntWr = busWe && busAddr >= A_SEC && busAddr <= A_YEAR;
  assign irq      = |flags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt <= '0; minCnt <= '0; hourCnt <= '0; domCnt <= '0;
      dowCnt <= '0; doyCnt <= '0; monCnt <= '0; yearCnt <= '0;
      alSec <= '0; alMin <= '0; alHour <= '0; alDom <= '0;
      alDow <= '0; alDoy <= '0; alMon <= '0; alYear <= '0;
      amask <= 8'hFF; incEn <= '0; flags <= '0; alarmChk <= 1'b0;
    end else begin
      if (strobe.tick) begin
        secCnt <= secWrap ? '0 : secCnt + 1'b1;
        if (secWrap) minCnt  <= (minCnt == 6'd59) ? '0 : minCnt + 1'b1;
        if (minWrap) hourCnt <= (hourCnt == 5'd23) ? '0 : hourCnt + 1'b1;
        if (dayInc) begin
          domCnt <= monWrap ? 5'd1 : domCnt + 1'b1;
          dowCnt <= (dowCnt >= 3'd6) ? '0 : dowCnt + 1'b1;
          doyCnt <= yearInc ? 9'd1 : doyCnt + 1'b1;
        end
        if (monWrap) monCnt  <= yearInc ? 4'd1 : monCnt + 1'b1;
        if (yearInc) yearCnt <= yearCnt + 1'b1;
      end
      if (wrAt(A_SEC))  secCnt  <= busWdata[5:0];
      if (wrAt(A_MIN))  minCnt  <= busWdata[5:0];
      if (wrAt(A_HOUR)) hourCnt <= busWdata[4:0];
      if (wrAt(A_DOM))  domCnt  <= busWdata[4:0];
      if (wrAt(A_DOW))  dowCnt  <= busWdata[2:0];
      if (wrAt(A_DOY))  doyCnt  <= busWdata[8:0];
      if (wrAt(A_MON))  monCnt  <= busWdata[3:0];
      if (wrAt(A_YEAR)) yearCnt <= busWdata[YEAR_W-1:0];
      if (wrAt(A_ALARM))         alSec  <= busWdata[5:0];
      if (wrAt(A_ALARM + 8'h04)) alMin  <= busWdata[5:0];
      if (wrAt(A_ALARM + 8'h08)) alHour <= busWdata[4:0];
      if (wrAt(A_ALARM + 8'h0C)) alDom  <= busWdata[4:0];
      if (wrAt(A_ALARM + 8'h10)) alDow  <= busWdata[2:0];
      if (wrAt(A_ALARM + 8'h14)) alDoy  <= busWdata[8:0];
      if (wrAt(A_ALARM + 8'h18)) alMon  <= busWdata[3:0];
      if (wrAt(A_ALARM + 8'h1C)) alYear <= busWdata[YEAR_W-1:0];
      if (wrAt(A_AMASK))  amask <= busWdata[7:0];
      if (wrAt(A_INC_EN)) incEn <= busWdata[7:0];
      alarmChk <= strobe.tick;
      flags[0] <= (flags[0] && !(wrFlags && busWdata[0])) || incHit;
      flags[1] <= (flags[1] && !(wrFlags && busWdata[1])) || alarmHit;
    end
  end

  for (genvar g = 0; g < GP_N; g++) begin : gScratch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) gp[g] <= '0;
      else if (wrAt(A_SCRATCH + 8'(4 * g))) gp[g] <= busWdata;
    end
  end

  always_comb begin
    dpRdata = '0;
    case (busAddr)
      A_FLAGS:  dpRdata = {30'd0, flags};
      A_INC_EN: dpRdata = {24'd0, incEn};
      A_AMASK:  dpRdata = {24'd0, amask};
      A_WORD0:  dpRdata = {5'd0, dowCnt, 3'd0, hourCnt, 2'd0, minCnt, 2'd0, secCnt};
      A_WORD1: begin
        dpRdata = {20'd0, monCnt, 3'd0, domCnt};
        dpRdata[16 +: YEAR_W] = yearCnt;
      end
      A_WORD2:  dpRdata = {23'd0, doyCnt};
      A_SEC:    dpRdata = {26'd0, secCnt};
      A_MIN:    dpRdata = {26'd0, minCnt};
      A_HOUR:   dpRdata = {27'd0, hourCnt};
      A_DOM:    dpRdata = {27'd0, domCnt};
      A_DOW:    dpRdata = {29'd0, dowCnt};
      A_DOY:    dpRdata = {23'd0, doyCnt};
      A_MON:    dpRdata = {28'd0, monCnt};
      A_YEAR:   dpRdata = DATA_W'(yearCnt);
      A_ALARM:         dpRdata = {26'd0, alSec};
      A_ALARM + 8'h04: dpRdata = {26'd0, alMin};
      A_ALARM + 8'h08: dpRdata = {27'd0, alHour};
      A_ALARM + 8'h0C: dpRdata = {27'd0, alDom};
      A_ALARM + 8'h10: dpRdata = {29'd0, alDow};
      A_ALARM + 8'h14: dpRdata = {23'd0, alDoy};
      A_ALARM + 8'h18: dpRdata = {28'd0, alMon};
      A_ALARM + 8'h1C: dpRdata = DATA_W'(alYear);
      default: ;
    endcase
    for (int i = 0; i < GP_N; i++)
      if (busAddr == A_SCRATCH + 8'(4 * i)) dpRdata = gp[i];
  end

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && secWrap && !anyCntWr) |=> secCnt == 6'd0);
  assert_year_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && yearInc && !anyCntWr) |=> (monCnt == 4'd1 && doyCnt == 9'd1));
  assert_alarm_after_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> $past(strobe.tick, 2));
  assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (amask == 8'hFF) |=> !$rose(flags[1]));
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlags && busWdata[1:0] == 2'b11 && !alarmHit && !incHit) |=> !irq);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_TICKS = 32768,
  parameter int CAL_W     = 17,
  parameter int YEAR_W    = 12,
  parameter int GP_N      = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refTick,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  rtcStrobeT   strobe;
  logic [31:0] ctrlRdata, dpRdata;

  rtc_ctrl #(.DIV_TICKS(DIV_TICKS), .CAL_W(CAL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .ctrlRdata(ctrlRdata), .strobe(strobe));

  rtc_datapath #(.YEAR_W(YEAR_W), .GP_N(GP_N)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .dpRdata(dpRdata), .irq(irq));

  assign busRdata = ctrlRdata | dpRdata;
endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb_top;
  localparam int DIV = 4;
  localparam logic [7:0] FLG = 8'h00, CTL = 8'h08, INC = 8'h0C, AMK = 8'h10,
    W0 = 8'h14, W1 = 8'h18, W2 = 8'h1C, SEC = 8'h20, MIN = 8'h24, HOUR = 8'h28,
    DOM = 8'h2C, DOW = 8'h30, DOY = 8'h34, MON = 8'h38, YEAR = 8'h3C, CAL = 8'h40,
    GP0 = 8'h44, ALS = 8'h60, ALM = 8'h64;

  logic clk = 1'b0, rstN = 1'b0, refTick = 1'b1, busWe = 1'b0, irq;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_calendar #(.DIV_TICKS(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .refTick(refTick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a; #1; check(req, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n divider periods with a fresh divider; extra carries control bit 4
  task automatic runSecs(input int n, input logic [31:0] extra);
    wr(CTL, 32'h2 | extra);
    wr(CTL, 32'h1 | extra);
    idle(DIV * n);
    wr(CTL, 32'h0);
  endtask

  task automatic setTime(input int y, input int mo, input int d, input int wd, input int yd,
                         input int h, input int mi, input int s);
    wr(SEC, 0); wr(YEAR, y); wr(MON, mo); wr(DOM, d); wr(DOW, wd); wr(DOY, yd);
    wr(HOUR, h); wr(MIN, mi); wr(SEC, s);
  endtask

  task automatic testReset;
    rdChk("R1 sec", SEC, 0); rdChk("R1 year", YEAR, 0); rdChk("R1 mask", AMK, 32'hFF);
    rdChk("R1 ctrl", CTL, 0); rdChk("R1 flags", FLG, 0); check("R1 irq", irq, 0);
  endtask

  task automatic testCount;
    setTime(2023, 5, 10, 2, 130, 8, 30, 10);
    runSecs(5, 0);
    rdChk("R2 sec after 5", SEC, 15); rdChk("R2 min", MIN, 30);
    wr(CTL, 3); idle(20); wr(CTL, 0);
    rdChk("R2 held divider", SEC, 15);
  endtask

  task automatic testDayMonth;
    setTime(2023, 2, 28, 6, 59, 23, 59, 58);
    runSecs(3, 0);
    rdChk("R3 sec", SEC, 1); rdChk("R3 min", MIN, 0); rdChk("R3 hour", HOUR, 0);
    rdChk("R3 dow wrap", DOW, 0); rdChk("R4 dom", DOM, 1); rdChk("R4 mon", MON, 3);
    rdChk("R4 doy", DOY, 60);
    setTime(2024, 2, 28, 3, 59, 23, 59, 59);
    runSecs(1, 0);
    rdChk("R4 leap dom", DOM, 29); rdChk("R4 leap mon", MON, 2);
    wr(HOUR, 23); wr(MIN, 59); wr(SEC, 59);
    runSecs(1, 0);
    rdChk("R4 leap end dom", DOM, 1); rdChk("R4 leap end mon", MON, 3);
    rdChk("R4 leap doy", DOY, 61);
  endtask

  task automatic testYear;
    setTime(2024, 12, 31, 3, 366, 23, 59, 59);
    runSecs(1, 0);
    rdChk("R5 mon", MON, 1); rdChk("R5 dom", DOM, 1); rdChk("R5 year", YEAR, 2025);
    rdChk("R5 doy", DOY, 1); rdChk("R5 dow", DOW, 4);
    wr(SEC, 42); wr(MIN, 21); wr(HOUR, 11);
    rdChk("R6 direct sec", SEC, 42); rdChk("R6 direct min", MIN, 21);
    rdChk("R7 word0", W0, 32'h040B152A); rdChk("R7 word1", W1, 32'h07E90101);
    rdChk("R7 word2", W2, 1);
  endtask

  task automatic testAlarm;
    setTime(2023, 7, 4, 1, 185, 10, 20, 3);
    wr(ALS, 5); wr(ALM, 33); wr(AMK, 32'hFE);
    runSecs(1, 0);
    rdChk("R8 no early match", FLG, 0);
    runSecs(1, 0);
    rdChk("R8 alarm flag", FLG, 2); check("R11 irq on alarm", irq, 1);
    wr(FLG, 2);
    rdChk("R11 flag cleared", FLG, 0); check("R11 irq low", irq, 0);
    wr(AMK, 32'hFF); wr(SEC, 3);
    runSecs(2, 0);
    rdChk("R9 mask off", FLG, 0); check("R9 irq", irq, 0);
  endtask

  task automatic testIncrement;
    wr(INC, 32'h02); wr(SEC, 58);
    runSecs(1, 0);
    rdChk("R10 seconds not enabled", FLG, 0);
    runSecs(1, 0);
    rdChk("R10 minute event", FLG, 1); check("R11 irq on event", irq, 1);
    wr(FLG, 1);
    rdChk("R11 event cleared", FLG, 0);
    wr(INC, 0);
  endtask

  task automatic testCal;
    wr(SEC, 0); wr(CAL, 32'h0_0002);
    runSecs(4, 0);
    rdChk("R12 forward", SEC, 6);
    wr(SEC, 0); wr(CAL, 32'h2_0002);
    runSecs(4, 0);
    rdChk("R12 backward", SEC, 2);
    wr(SEC, 0);
    runSecs(4, 32'h10);
    rdChk("R12 disabled", SEC, 4);
    wr(CAL, 0);
  endtask

  task automatic testScratch;
    for (int i = 0; i < 5; i++) wr(GP0 + 8'(4 * i), 32'hA5000000 + i * 32'h1111);
    for (int i = 0; i < 5; i++) rdChk("R13 scratch", GP0 + 8'(4 * i), 32'hA5000000 + i * 32'h1111);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset;
    testCount;
    testDayMonth;
    testYear;
    testAlarm;
    testIncrement;
    testCal;
    testScratch;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule